// File: doc/BRIEF.md
# Screen-Stripe Framebuffer Write Router

This block sits between the color-output stages of four GPU modules and a framebuffer that is spread over four memory partitions, one partition per module. The frame is cut into vertical stripes, and the stripe that contains a pixel's x coordinate decides which partition owns it. Every module's output stage takes part in composing the frame. No single module gathers all the pixels.

Each module presents at most one pixel write per cycle: x, y and a color word, with a valid/ready handshake. The router works out the owning partition from x and three programmable stripe edges. A write owned by the sender's own partition goes straight to that partition's arbiter. Any other write is pushed into a small link FIFO, one FIFO for each source and destination pair. Each partition picks one write per cycle, round-robin, from its local source and the link FIFOs that lead to it. The winner appears on a registered partition write port, tagged with the module that sent it.

Top module: `sfb_router`

## Requirements
- R1: While reset is held and in the first cycle after it, no partition write port is valid.
- R2: The owning partition is the count of stripe edges `cfg_bound[k*12 +: 12]` (k = 0, 1, 2) that are less than or equal to x. The edges are expected to be non-decreasing, so x equal to an edge belongs to the stripe above that edge.
- R3: A write accepted from module m that m's own partition owns appears on partition m's port in the next cycle. It carries the same x, y and color, and `part_src` equals m.
- R4: A write accepted from module m that another partition p owns appears on partition p's port two cycles after acceptance when p has no other traffic. It carries the same x, y and color, and `part_src` equals m.
- R5: Each partition grants round-robin among its requesters, numbered by source module. The search starts one past the last source granted and wraps around. One write leaves a partition per cycle at most.
- R6: A write toward a remote partition is refused (`src_ready` low) while the link FIFO from that source to that partition is full. A refused write is not delivered.
- R7: Writes from one source to one partition leave that partition in the order they were accepted, and none are lost or duplicated.
- R8: A change to the stripe edges takes effect for writes presented after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bound | input | 36 | Three stripe edges, 12 bits each, edge k at bits [k*12 +: 12] |
| src_valid | input | 4 | Write request per source module |
| src_x | input | 48 | Pixel x per source, 12 bits each |
| src_y | input | 48 | Pixel y per source, 12 bits each |
| src_color | input | 128 | Pixel color per source, 32 bits each |
| src_ready | output | 4 | Write accepted this cycle, per source |
| part_valid | output | 4 | Write leaving each partition |
| part_x | output | 48 | x of the write leaving each partition |
| part_y | output | 48 | y of the write leaving each partition |
| part_color | output | 128 | Color of the write leaving each partition |
| part_src | output | 8 | Sending module per partition, 2 bits each |

## Verification
Single writes are swept over x values on both sides of every stripe edge and at the ends of the coordinate range, from each source. This tells a wrong comparison direction or an off-by-one edge apart from a correct decode, and it tells the one-cycle local path apart from the two-cycle link path. Four sources writing to one partition in the same cycle show the exact grant order, which separates true rotation from a fixed priority. A long flood from a remote and a local source into one partition fills a link FIFO and shows both the stall and the ordering. Moving an edge, then sending writes again, shows that the decode follows the new setting.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int XW = 12;
    localparam int YW = 12;
    localparam int CW = 32;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [CW-1:0] color;
    } pix_t;
endpackage

// File: rtl/sfb_owner_dec.sv
module sfb_owner_dec
    import sfb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [XW-1:0]       x,
    input  logic [(N-1)*XW-1:0] bounds,
    output logic [IW-1:0]       owner
);
    // Count edges at or below x; monotonic edges give the stripe index.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < N - 1; k++) begin
            if (x >= bounds[k*XW +: XW]) cnt = cnt + 1;
        end
        owner = IW'(cnt);
    end
endmodule

// File: rtl/sfb_link_fifo.sv
module sfb_link_fifo
    import sfb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  pix_t din,
    input  logic pop,
    output pix_t dout,
    output logic full,
    output logic empty
);
    typedef struct packed {
        pix_t [DEPTH-1:0] mem;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [AW:0]      cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full    = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign dout    = st_q.mem[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
        end
        st_d.cnt = st_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfb_rr_arb.sv
module sfb_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(st_q.ptr) + i) % N;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
        if (any) st_d.ptr = (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfb_router.sv
module sfb_router
    import sfb_pkg::*;
#(
    parameter int N          = 4,
    parameter int FIFO_DEPTH = 4,
    localparam int SW        = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [(N-1)*XW-1:0] cfg_bound,
    input  logic [N-1:0]        src_valid,
    input  logic [N*XW-1:0]     src_x,
    input  logic [N*YW-1:0]     src_y,
    input  logic [N*CW-1:0]     src_color,
    output logic [N-1:0]        src_ready,
    output logic [N-1:0]        part_valid,
    output logic [N*XW-1:0]     part_x,
    output logic [N*YW-1:0]     part_y,
    output logic [N*CW-1:0]     part_color,
    output logic [N*SW-1:0]     part_src
);
    typedef struct packed {
        logic          vld;
        logic [SW-1:0] src;
        pix_t          pix;
    } pout_t;

    typedef struct packed {
        pout_t [N-1:0] part;
    } rt_st_t;

    rt_st_t st_d, st_q;

    pix_t                 src_pix [N];
    logic [SW-1:0]        own     [N];
    logic [N-1:0]         is_local;
    logic [N-1:0][N-1:0]  push;
    logic [N-1:0][N-1:0]  pop;
    logic [N-1:0][N-1:0]  full;
    logic [N-1:0][N-1:0]  empty;
    pix_t                 fdout   [N][N];
    logic [N-1:0]         arb_req [N];
    logic [N*N-1:0]       arb_gnt;
    logic [SW-1:0]        arb_idx [N];
    logic [N-1:0]         arb_any;

    // Per-source unpacking and ownership decode
    for (genvar m = 0; m < N; m++) begin : g_src
        assign src_pix[m].x     = src_x[m*XW +: XW];
        assign src_pix[m].y     = src_y[m*YW +: YW];
        assign src_pix[m].color = src_color[m*CW +: CW];

        sfb_owner_dec #(.N(N), .IW(SW)) u_dec (
            .x      (src_x[m*XW +: XW]),
            .bounds (cfg_bound),
            .owner  (own[m])
        );
        assign is_local[m] = (own[m] == SW'(m));
    end

    // One link FIFO per ordered pair of distinct modules
    for (genvar q = 0; q < N; q++) begin : g_lsrc
        for (genvar d = 0; d < N; d++) begin : g_ldst
            if (q != d) begin : g_link
                sfb_link_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .push  (push[q][d]),
                    .din   (src_pix[q]),
                    .pop   (pop[q][d]),
                    .dout  (fdout[q][d]),
                    .full  (full[q][d]),
                    .empty (empty[q][d])
                );
            end else begin : g_self
                assign fdout[q][d] = '0;
                assign full[q][d]  = 1'b1;
                assign empty[q][d] = 1'b1;
            end
        end
    end

    // Per-partition arbiters
    for (genvar p = 0; p < N; p++) begin : g_part
        sfb_rr_arb #(.N(N), .IW(SW)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (arb_req[p]),
            .gnt     (arb_gnt[p*N +: N]),
            .gnt_idx (arb_idx[p]),
            .any     (arb_any[p])
        );
        assign part_valid[p]          = st_q.part[p].vld;
        assign part_src[p*SW +: SW]   = st_q.part[p].src;
        assign part_x[p*XW +: XW]     = st_q.part[p].pix.x;
        assign part_y[p*YW +: YW]     = st_q.part[p].pix.y;
        assign part_color[p*CW +: CW] = st_q.part[p].pix.color;
    end

    // Requests seen by each partition
    always_comb begin
        for (int p = 0; p < N; p++) begin
            for (int q = 0; q < N; q++) begin
                if (q == p) arb_req[p][q] = src_valid[p] && is_local[p];
                else        arb_req[p][q] = !empty[q][p];
            end
        end
    end

    // Link pushes, link pops and source handshake
    always_comb begin
        push      = '0;
        pop       = '0;
        src_ready = '0;
        for (int m = 0; m < N; m++) begin
            for (int d = 0; d < N; d++) begin
                if (d != m && src_valid[m] && !is_local[m] && own[m] == SW'(d) && !full[m][d])
                    push[m][d] = 1'b1;
            end
            src_ready[m] = is_local[m] ? arb_gnt[m*N + m] : !full[m][own[m]];
        end
        for (int p = 0; p < N; p++) begin
            for (int q = 0; q < N; q++) begin
                if (q != p) pop[q][p] = arb_gnt[p*N + q];
            end
        end
    end

    // Registered partition write ports
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < N; p++) begin
            st_d.part[p].vld = arb_any[p];
            if (arb_any[p]) begin
                st_d.part[p].src = arb_idx[p];
                st_d.part[p].pix = (arb_idx[p] == SW'(p)) ? src_pix[p] : fdout[arb_idx[p]][p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfb_router_chk.sv
module sfb_router_chk
    import sfb_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [(N-1)*XW-1:0] cfg_bound,
    input logic [N-1:0]        src_valid,
    input logic [N*XW-1:0]     src_x,
    input logic [N-1:0]        src_ready,
    input logic [N-1:0]        part_valid,
    input logic [N*XW-1:0]     part_x,
    input logic [N*SW-1:0]     part_src,
    input logic [N*N-1:0]      arb_gnt
);
    function automatic int stripe_of(input logic [XW-1:0] xv, input logic [(N-1)*XW-1:0] b);
        int c;
        c = 0;
        for (int k = 0; k < N - 1; k++) if (xv >= b[k*XW +: XW]) c = c + 1;
        return c;
    endfunction

    for (genvar p = 0; p < N; p++) begin : g_chk
        // R2
        owner_stripe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            part_valid[p] |-> stripe_of(part_x[p*XW +: XW], cfg_bound) == p);

        // R3
        local_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_valid[p] && src_ready[p] && stripe_of(src_x[p*XW +: XW], cfg_bound) == p)
            |=> (part_valid[p] && part_src[p*SW +: SW] == SW'(p)));

        // R3
        local_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (part_valid[p] && part_src[p*SW +: SW] == SW'(p))
            |-> $past(src_valid[p] && src_ready[p]));

        // R5
        single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(arb_gnt[p*N +: N]));
    end
endmodule

bind sfb_router sfb_router_chk #(.N(N), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bound  (cfg_bound),
    .src_valid  (src_valid),
    .src_x      (src_x),
    .src_ready  (src_ready),
    .part_valid (part_valid),
    .part_x     (part_x),
    .part_src   (part_src),
    .arb_gnt    (arb_gnt)
);

// File: tb/sfb_router_tb.sv
module sfb_router_tb;
    import sfb_pkg::*;

    localparam int N  = 4;
    localparam int SW = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [(N-1)*XW-1:0] cfg_bound;
    logic [N-1:0]        src_valid;
    logic [N*XW-1:0]     src_x;
    logic [N*YW-1:0]     src_y;
    logic [N*CW-1:0]     src_color;
    logic [N-1:0]        src_ready;
    logic [N-1:0]        part_valid;
    logic [N*XW-1:0]     part_x;
    logic [N*YW-1:0]     part_y;
    logic [N*CW-1:0]     part_color;
    logic [N*SW-1:0]     part_src;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sfb_router #(.N(N), .FIFO_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bound(cfg_bound),
        .src_valid(src_valid), .src_x(src_x), .src_y(src_y), .src_color(src_color),
        .src_ready(src_ready), .part_valid(part_valid), .part_x(part_x),
        .part_y(part_y), .part_color(part_color), .part_src(part_src)
    );

    // {source, x, expected partition} with edges 100 / 200 / 300
    localparam int VEC [12][3] = '{
        '{0, 5, 0},   '{0, 99, 0},  '{0, 100, 1}, '{1, 150, 1},
        '{1, 199, 1}, '{2, 200, 2}, '{3, 299, 2}, '{3, 300, 3},
        '{2, 4095, 3},'{3, 0, 0},   '{1, 250, 2}, '{0, 350, 3}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] col_of(input int s, input int x);
        return 32'hC0DE_0000 + CW'(s << 12) + CW'(x);
    endfunction

    task automatic send_one(input int s, input int x, input int ep, input string req);
        int lat;
        @(negedge clk);
        src_x[s*XW +: XW]     = XW'(x);
        src_y[s*YW +: YW]     = YW'((x * 3 + s) % 4096);
        src_color[s*CW +: CW] = col_of(s, x);
        src_valid[s]          = 1'b1;
        #1;
        chk(src_ready[s] == 1'b1, req, "idle write accepted", src_ready[s], 1);
        @(negedge clk);
        src_valid[s] = 1'b0;
        lat = (ep == s) ? 1 : 2;
        if (lat == 2) begin
            chk(part_valid == '0, "R4", "no output one cycle after remote accept", part_valid, 0);
            @(negedge clk);
        end
        chk(part_valid == N'(1 << ep), req, "partition valid pattern", part_valid, 1 << ep);
        chk(part_x[ep*XW +: XW] == XW'(x) && part_y[ep*YW +: YW] == YW'((x * 3 + s) % 4096)
            && part_color[ep*CW +: CW] == col_of(s, x) && part_src[ep*SW +: SW] == SW'(s),
            req, "payload and source tag", part_color[ep*CW +: CW], col_of(s, x));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        src_valid = '0; src_x = '0; src_y = '0; src_color = '0;
        cfg_bound = {12'd300, 12'd200, 12'd100};
        repeat (3) @(negedge clk);
        // R1: held in reset
        chk(part_valid == '0, "R1", "valid during reset", part_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(part_valid == '0, "R1", "valid after reset", part_valid, 0);

        // R2 R3 R4: decode sweep over stripe edges, local and remote paths
        for (int i = 0; i < 12; i++) begin
            send_one(VEC[i][0], VEC[i][1], VEC[i][2], (VEC[i][0] == VEC[i][2]) ? "R3" : "R2");
        end

        // R5: all four sources hit partition 2 in the same cycle
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
            src_x[s*XW +: XW]     = 12'd250;
            src_color[s*CW +: CW] = 32'h5000_0000 + CW'(s);
            src_valid[s]          = 1'b1;
        end
        #1;
        chk(src_ready == 4'hF, "R5", "all four accepted", src_ready, 4'hF);
        @(negedge clk);
        src_valid = '0;
        begin
            int order [4] = '{2, 3, 0, 1};
            for (int k = 0; k < 4; k++) begin
                chk(part_valid == 4'b0100 && part_src[2*SW +: SW] == SW'(order[k]),
                    "R5", "grant order", part_src[2*SW +: SW], order[k]);
                @(negedge clk);
            end
        end

        // R6 R7: flood partition 1 from remote source 0 and local source 1
        begin
            int  c0 = 0, c1 = 0, r0 = 0, r1 = 0, bad = 0;
            bit  acc0 = 0, acc1 = 0, stall = 0;
            for (int cyc = 0; cyc < 60; cyc++) begin
                @(negedge clk);
                if (part_valid[1]) begin
                    if (part_src[1*SW +: SW] == 2'd0) begin
                        if (part_color[1*CW +: CW] != 32'h1000_0000 + CW'(r0)) bad++;
                        r0++;
                    end else begin
                        if (part_color[1*CW +: CW] != 32'h2000_0000 + CW'(r1)) bad++;
                        r1++;
                    end
                end
                if (part_valid[0] || part_valid[2] || part_valid[3]) bad++;
                if (acc0) c0++;
                if (acc1) c1++;
                src_valid[0] = (cyc < 40);
                src_valid[1] = (cyc < 40);
                src_x[0*XW +: XW] = 12'd150;
                src_x[1*XW +: XW] = 12'd120;
                src_color[0*CW +: CW] = 32'h1000_0000 + CW'(c0);
                src_color[1*CW +: CW] = 32'h2000_0000 + CW'(c1);
                #1;
                acc0 = src_valid[0] && src_ready[0];
                acc1 = src_valid[1] && src_ready[1];
                if (src_valid[0] && !src_ready[0]) stall = 1;
            end
            chk(stall, "R6", "remote source stalled on full link", stall, 1);
            chk(r0 == c0 && c0 > 0, "R7", "remote writes delivered count", r0, c0);
            chk(r1 == c1 && c1 > 0, "R7", "local writes delivered count", r1, c1);
            chk(bad == 0, "R7", "order and routing mismatches", bad, 0);
        end

        // R8: move the first edge down to 50
        @(negedge clk);
        cfg_bound = {12'd300, 12'd200, 12'd50};
        send_one(1, 60, 1, "R8");
        send_one(1, 40, 0, "R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule